// File: doc/BRIEF.md
# Audio Link Output Frame Serializer

This block sits on the controller side of a serial audio codec link. It builds one outgoing frame at a time and shifts it out on a single data line, one bit per bit-clock cycle. A frame marker line is held high for the opening tag slot of each frame. A frame has a 16-bit tag slot followed by twelve 20-bit slots, so it lasts 256 bit times. The tag announces which of the later slots carry meaning.

Once per frame, on the last bit time of the previous frame, the block takes a snapshot of its inputs. These are an optional control-register command (read or write, a 7-bit register index and 16 bits of write data), a left and a right playback sample, a resolution code and a mono flag. The command fills slots 1 and 2. The playback samples fill slots 3 and 4, aligned to the most significant bit, with the unused low bits forced to zero. Every slot that carries nothing is sent as all zeros. The block runs on the bit clock, and its registered outputs change on the rising edge, so the codec can sample them on the falling edge.

Top module: `audio_frame_serializer`

## Requirements
- R1: A frame is 256 bit times long and frames follow one another without gaps; `sync` is high for the first 16 bit times of each frame and low for the other 240.
- R2: The tag slot is sent first, its bit 15 first. Bit 15 is 1 when any slot is flagged. Bits 14 and 13 flag slots 1 and 2 and equal the snapshotted `cmd_valid`. Bits 12 and 11 flag slots 3 and 4 and equal the snapshotted `pcm_valid`. Bits 10:0 are 0.
- R3: With a command pending, slot 1 carries bit 19 = 1 for a read and 0 for a write, bits 18:12 = `cmd_index`, and bits 11:0 = 0. Every slot is sent bit 19 first.
- R4: On a pending write, slot 2 carries `cmd_wdata` in bits 19:4 with bits 3:0 = 0. On a pending read, slot 2 is all zeros.
- R5: Playback samples arrive right-aligned. `res_sel` picks the resolution: 0 = 8 bits, 1 = 16 bits, 2 = 18 bits, 3 = 20 bits. The sample's low N bits go to slot bits 19:(20-N) and the remaining low slot bits are 0. Input bits above bit N-1 are ignored.
- R6: With `mono` = 1, slot 4 carries the justified left sample, the same as slot 3, and `right_sample` is ignored.
- R7: A slot with no content is all zeros. This covers slots 1 and 2 with no command, slots 3 and 4 with `pcm_valid` = 0, and slots 5 to 12 always.
- R8: While `rst` is high, `sync`, `sdata` and `cmd_taken` are 0. The first frame starts on the first rising edge with `rst` low.
- R9: Inputs are snapshotted only on the edge that starts a frame, so changes during a frame do not affect that frame. `cmd_taken` is high for exactly the first bit time of a frame that carries a command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is pending for the next frame |
| cmd_read | input | 1 | 1 = register read, 0 = register write |
| cmd_index | input | 7 | Control register index |
| cmd_wdata | input | 16 | Register write data |
| pcm_valid | input | 1 | Playback samples present for the next frame |
| mono | input | 1 | Duplicate the left sample into the right slot |
| res_sel | input | 2 | Sample resolution code (8/16/18/20 bits) |
| left_sample | input | 20 | Left sample, right-aligned |
| right_sample | input | 20 | Right sample, right-aligned |
| sync | output | 1 | Frame marker, high during the tag slot |
| sdata | output | 1 | Serial frame data, MSB first |
| cmd_taken | output | 1 | Pulse: the frame now starting carries the command |

## Verification
A bad bit-position counter shows up at the ports within one frame. `sync` would rise after a number of bit times other than 256, or stay high for a number other than 16. Every later slot would also sit at the wrong offset, so the first decoded frame shows the error. A wrong snapshot or packing state can only appear in the slot that holds it. The bench therefore decodes every frame completely and compares the tag, slots 1 to 4 and the zero tail against expected values. It also changes the inputs halfway through each frame to catch a snapshot taken at the wrong time. Resolution, mono and command-type errors show up in the first frame that uses the faulty combination.

// File: rtl/afs_pkg.sv
package afs_pkg;
  // Resolution codes for playback samples
  typedef enum logic [1:0] {
    RES_8  = 2'd0,
    RES_16 = 2'd1,
    RES_18 = 2'd2,
    RES_20 = 2'd3
  } res_e;
endpackage

// File: rtl/afs_frame_timer.sv
module afs_frame_timer #(
  parameter int FRAME_W = 256,
  parameter int SYNC_W  = 16,
  localparam int CW     = $clog2(FRAME_W)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          load,
  output logic          sync_d
);
  localparam logic [CW-1:0] LAST = CW'(FRAME_W - 1);

  logic [CW-1:0] pos_q;
  logic [CW-1:0] pos_n;

  // The position rests on the last bit after reset, so the first edge with rst low starts a frame
  always_ff @(posedge clk) begin
    if (rst) pos_q <= LAST;
    else     pos_q <= pos_n;
  end

  assign load   = (pos_q == LAST);
  assign pos_n  = load ? '0 : pos_q + 1'b1;
  assign sync_d = (pos_n < CW'(SYNC_W));
endmodule

// File: rtl/afs_slot_pack.sv
module afs_slot_pack
  import afs_pkg::*;
#(
  parameter int SLOT_W = 20,
  parameter int NSLOT  = 12,
  parameter int TAG_W  = 16,
  parameter int IDX_W  = 7,
  parameter int DATA_W = 16,
  localparam int FRAME_W = TAG_W + NSLOT * SLOT_W
) (
  input  logic               cmd_valid,
  input  logic               cmd_read,
  input  logic [IDX_W-1:0]   cmd_index,
  input  logic [DATA_W-1:0]  cmd_wdata,
  input  logic               pcm_valid,
  input  logic               mono,
  input  res_e               res,
  input  logic [SLOT_W-1:0]  left_sample,
  input  logic [SLOT_W-1:0]  right_sample,
  output logic [FRAME_W-1:0] frame_word
);
  logic [SLOT_W-1:0] slot [NSLOT];
  logic [NSLOT-1:0]  flag;          // flag[NSLOT-1] is slot 1
  logic [SLOT_W-1:0] left_j, right_j;
  logic [TAG_W-1:0]  tag;

  function automatic logic [SLOT_W-1:0] justify(input logic [SLOT_W-1:0] s, input res_e r);
    case (r)
      RES_8:   return s << (SLOT_W - 8);
      RES_16:  return s << (SLOT_W - 16);
      RES_18:  return s << (SLOT_W - 18);
      default: return s;
    endcase
  endfunction

  assign left_j  = justify(left_sample, res);
  assign right_j = justify(mono ? left_sample : right_sample, res);

  always_comb begin
    for (int i = 0; i < NSLOT; i++) slot[i] = '0;
    flag = '0;
    if (cmd_valid) begin
      slot[0] = {cmd_read, cmd_index, {(SLOT_W-1-IDX_W){1'b0}}};
      if (!cmd_read) slot[1] = {cmd_wdata, {(SLOT_W-DATA_W){1'b0}}};
      flag[NSLOT-1] = 1'b1;
      flag[NSLOT-2] = 1'b1;
    end
    if (pcm_valid) begin
      slot[2] = left_j;
      slot[3] = right_j;
      flag[NSLOT-3] = 1'b1;
      flag[NSLOT-4] = 1'b1;
    end
  end

  assign tag = {|flag, flag, {(TAG_W-1-NSLOT){1'b0}}};
  assign frame_word[FRAME_W-1 -: TAG_W] = tag;

  for (genvar g = 0; g < NSLOT; g++) begin : g_place
    assign frame_word[FRAME_W-TAG_W-1-g*SLOT_W -: SLOT_W] = slot[g];
  end
endmodule

// File: rtl/afs_shifter.sv
module afs_shifter #(
  parameter int FRAME_W = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               sync_d,
  input  logic [FRAME_W-1:0] frame_word,
  output logic               sync,
  output logic               sdata
);
  logic [FRAME_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      sdata <= 1'b0;
      sync  <= 1'b0;
    end else begin
      sync <= sync_d;
      if (load) begin
        sdata <= frame_word[FRAME_W-1];
        sh_q  <= {frame_word[FRAME_W-2:0], 1'b0};
      end else begin
        sdata <= sh_q[FRAME_W-1];
        sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/audio_frame_serializer.sv
module audio_frame_serializer
  import afs_pkg::*;
#(
  parameter int SLOT_W = 20,
  parameter int NSLOT  = 12,
  parameter int TAG_W  = 16,
  parameter int IDX_W  = 7,
  parameter int DATA_W = 16,
  localparam int FRAME_W = TAG_W + NSLOT * SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_read,
  input  logic [IDX_W-1:0]  cmd_index,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              pcm_valid,
  input  logic              mono,
  input  logic [1:0]        res_sel,
  input  logic [SLOT_W-1:0] left_sample,
  input  logic [SLOT_W-1:0] right_sample,
  output logic              sync,
  output logic              sdata,
  output logic              cmd_taken
);
  logic               load;
  logic               sync_d;
  logic [FRAME_W-1:0] frame_word;

  afs_frame_timer #(.FRAME_W(FRAME_W), .SYNC_W(TAG_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .sync_d (sync_d)
  );

  afs_slot_pack #(
    .SLOT_W(SLOT_W), .NSLOT(NSLOT), .TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) u_pack (
    .cmd_valid    (cmd_valid),
    .cmd_read     (cmd_read),
    .cmd_index    (cmd_index),
    .cmd_wdata    (cmd_wdata),
    .pcm_valid    (pcm_valid),
    .mono         (mono),
    .res          (res_e'(res_sel)),
    .left_sample  (left_sample),
    .right_sample (right_sample),
    .frame_word   (frame_word)
  );

  afs_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .sync_d     (sync_d),
    .frame_word (frame_word),
    .sync       (sync),
    .sdata      (sdata)
  );

  always_ff @(posedge clk) begin
    if (rst) cmd_taken <= 1'b0;
    else     cmd_taken <= load & cmd_valid;
  end
endmodule

// File: rtl/afs_checker.sv
module afs_checker #(
  parameter int FRAME_W = 256,
  parameter int SYNC_W  = 16
) (
  input logic clk,
  input logic rst,
  input logic cmd_valid,
  input logic pcm_valid,
  input logic sync,
  input logic sdata,
  input logic cmd_taken
);
  logic sync_q;
  logic seen;
  int   pos;
  logic rise;

  assign rise = sync & ~sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 1'b0;
      seen   <= 1'b0;
      pos    <= 0;
    end else begin
      sync_q <= sync;
      if (rise) begin
        seen <= 1'b1;
        pos  <= 1;
      end else if (pos <= FRAME_W) begin
        pos <= pos + 1;
      end
    end
  end

  // R1: frame starts are FRAME_W bit times apart
  assert_frame_period_R1: assert property (@(posedge clk) disable iff (rst)
    (seen && rise) |-> (pos == FRAME_W));

  // R1: sync high exactly for the tag slot
  assert_sync_width_R1: assert property (@(posedge clk) disable iff (rst)
    (seen && !rise) |-> (sync == (pos < SYNC_W)));

  // R2: first tag bit reflects whether anything was flagged
  assert_tag_valid_R2: assert property (@(posedge clk) disable iff (rst)
    rise |-> (sdata == ($past(cmd_valid) || $past(pcm_valid))));

  // R9: cmd_taken only in the first bit time of a frame
  assert_taken_at_start_R9: assert property (@(posedge clk) disable iff (rst)
    cmd_taken |-> rise);

  // R9: cmd_taken follows the snapshotted command request
  assert_taken_matches_R9: assert property (@(posedge clk) disable iff (rst)
    rise |-> (cmd_taken == $past(cmd_valid)));

  // R8: outputs quiet after a reset cycle
  assert_reset_quiet_R8: assert property (@(posedge clk)
    rst |=> (!sync && !sdata && !cmd_taken));
endmodule

bind audio_frame_serializer afs_checker #(.FRAME_W(FRAME_W), .SYNC_W(TAG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .pcm_valid (pcm_valid),
  .sync      (sync),
  .sdata     (sdata),
  .cmd_taken (cmd_taken)
);

// File: tb/audio_frame_serializer_bench.sv
`timescale 1ns/1ps
module audio_frame_serializer_bench;
  typedef struct packed {
    logic        cv;
    logic        rd;
    logic [6:0]  idx;
    logic [15:0] wd;
    logic        pv;
    logic        mono;
    logic [1:0]  res;
    logic [19:0] l;
    logic [19:0] r;
  } stim_t;

  logic clk = 1'b0;
  logic rst;
  logic cmd_valid, cmd_read, pcm_valid, mono;
  logic [6:0]  cmd_index;
  logic [15:0] cmd_wdata;
  logic [1:0]  res_sel;
  logic [19:0] left_sample, right_sample;
  logic sync, sdata, cmd_taken;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  audio_frame_serializer u_audio_frame_serializer (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
    .cmd_index(cmd_index), .cmd_wdata(cmd_wdata), .pcm_valid(pcm_valid),
    .mono(mono), .res_sel(res_sel), .left_sample(left_sample),
    .right_sample(right_sample), .sync(sync), .sdata(sdata), .cmd_taken(cmd_taken)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input stim_t s);
    cmd_valid = s.cv; cmd_read = s.rd; cmd_index = s.idx; cmd_wdata = s.wd;
    pcm_valid = s.pv; mono = s.mono; res_sel = s.res;
    left_sample = s.l; right_sample = s.r;
  endtask

  function automatic logic [19:0] just(input logic [1:0] res, input logic [19:0] s);
    case (res)
      2'd0:    return {s[7:0], 12'h000};
      2'd1:    return {s[15:0], 4'h0};
      2'd2:    return {s[17:0], 2'b00};
      default: return s;
    endcase
  endfunction

  function automatic logic [15:0] exp_tag(input stim_t s);
    logic [11:0] f;
    f = {s.cv, s.cv, s.pv, s.pv, 8'h00};
    return {|f, f, 3'b000};
  endfunction

  function automatic logic [19:0] exp_slot(input stim_t s, input int n);
    case (n)
      1: return s.cv ? {s.rd, s.idx, 12'h000} : 20'h0;
      2: return (s.cv && !s.rd) ? {s.wd, 4'h0} : 20'h0;
      3: return s.pv ? just(s.res, s.l) : 20'h0;
      4: return s.pv ? just(s.res, s.mono ? s.l : s.r) : 20'h0;
      default: return 20'h0;
    endcase
  endfunction

  // Shift one frame in at negedges; apply the next stimulus mid-frame
  task automatic run_frame(input stim_t cur, input stim_t nxt);
    logic [255:0] fr;
    int sync_bad;
    int tail_ones;
    sync_bad = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      fr[255-i] = sdata;
      if (sync !== (i < 16)) sync_bad++;
      if (i == 0) chk(cmd_taken === cur.cv, "R9 cmd_taken at frame start", 32'(cmd_taken), 32'(cur.cv));
      if (i == 1) chk(cmd_taken === 1'b0, "R9 cmd_taken one bit time", 32'(cmd_taken), 32'd0);
      if (i == 120) apply(nxt);
    end
    chk(sync_bad == 0, "R1 sync pattern mismatches", 32'(sync_bad), 32'd0);
    chk(fr[255:240] === exp_tag(cur), "R2 tag", 32'(fr[255:240]), 32'(exp_tag(cur)));
    chk(fr[239:220] === exp_slot(cur, 1), "R3 slot1 command", 32'(fr[239:220]), 32'(exp_slot(cur, 1)));
    chk(fr[219:200] === exp_slot(cur, 2), "R4 slot2 data", 32'(fr[219:200]), 32'(exp_slot(cur, 2)));
    chk(fr[199:180] === exp_slot(cur, 3), "R5 R9 slot3 left", 32'(fr[199:180]), 32'(exp_slot(cur, 3)));
    chk(fr[179:160] === exp_slot(cur, 4), "R5 R6 slot4 right", 32'(fr[179:160]), 32'(exp_slot(cur, 4)));
    tail_ones = $countones(fr[159:0]);
    chk(tail_ones == 0, "R7 slots 5-12 zero", 32'(tail_ones), 32'd0);
  endtask

  function automatic stim_t directed(input int k);
    stim_t s;
    s = '0;
    case (k)
      0: begin s.cv = 1; s.rd = 0; s.idx = 7'h2A; s.wd = 16'hBEEF; s.pv = 1; s.res = 3; s.l = 20'hABCDE; s.r = 20'h12345; end
      1: begin s.cv = 1; s.rd = 1; s.idx = 7'h7F; s.wd = 16'hFFFF; s.pv = 0; s.l = 20'hFFFFF; s.r = 20'hFFFFF; end
      2: begin s.cv = 0; s.rd = 1; s.idx = 7'h55; s.wd = 16'h1234; s.pv = 0; s.l = 20'hFFFFF; s.r = 20'hFFFFF; end
      3: begin s.pv = 1; s.mono = 1; s.res = 0; s.l = 20'hFFF5A; s.r = 20'h00077; end
      4: begin s.pv = 1; s.res = 1; s.l = 20'hF8001; s.r = 20'h0FFFF; end
      5: begin s.pv = 1; s.res = 2; s.l = 20'hC0003; s.r = 20'h3FFFF; end
      6: begin s.cv = 1; s.rd = 0; s.idx = 7'h00; s.wd = 16'h0001; s.pv = 1; s.mono = 1; s.res = 3; s.l = 20'h80001; s.r = 20'h7FFFE; end
      default: begin
        s.cv = 1'($urandom); s.rd = 1'($urandom); s.idx = 7'($urandom); s.wd = 16'($urandom);
        s.pv = 1'($urandom); s.mono = 1'($urandom); s.res = 2'($urandom);
        s.l = 20'($urandom); s.r = 20'($urandom);
      end
    endcase
    return s;
  endfunction

  initial begin
    stim_t cur, nxt;
    void'($urandom(32'd20240611));
    rst = 1'b1;
    cur = directed(0);
    apply(cur);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(sync === 1'b0, "R8 sync in reset", 32'(sync), 32'd0);
    chk(sdata === 1'b0, "R8 sdata in reset", 32'(sdata), 32'd0);
    chk(cmd_taken === 1'b0, "R8 cmd_taken in reset", 32'(cmd_taken), 32'd0);
    rst = 1'b0;
    // R8: the first negedge after release must already show the tag slot (checked in run_frame)
    for (int k = 1; k <= 30; k++) begin
      nxt = directed(k);
      run_frame(cur, nxt);
      cur = nxt;
    end
    // Mid-run reset: outputs clear at once (R8)
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(sync === 1'b0 && sdata === 1'b0, "R8 outputs after mid-run reset", {30'd0, sync, sdata}, 32'd0);
    rst = 1'b0;
    run_frame(cur, directed(0));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule